// File: doc/BRIEF.md
# Low Power Mode Sequencer

This block sequences a small processor subsystem into and out of four low-power modes: IDLE, STANDBY, HALT and HIBERNATE. Software programs a 32-bit control register with the target mode, a standby wake filter length, a watchdog wake enable, and the memory-retention and IO-isolation choices for HIBERNATE. The CPU then raises a one-cycle pulse when it executes its idle instruction. Only that pulse starts the power-down.

While asleep, the block drives four clock enables: CPU clock, peripheral clock, watchdog clock and oscillator/PLL. Each mode has a fixed pattern of these enables. The block returns to run when it sees the wake source that belongs to the active mode. On the way back it re-enables the clocks in a fixed order and ends with a one-cycle wake-done pulse.

The block runs on the always-on oscillator clock. Its asynchronous reset is released synchronously by a two-stage synchronizer inside the block.

Top module: `lpm_sequencer`

## Requirements
- R1: The control register resets to 0x000000FC. A write stores only bits [1:0] (mode), [7:2] (standby filter N), [15] (watchdog wake enable), [17:16] (memory select) and [31] (isolation request). All other bits read back as zero, so the write mask is 0x800380FF.
- R2: While in run (lp_active low), all four clock enables are high.
- R3: While asleep, the enables {cpu,per,wdog,osc} follow the mode in bits [1:0]: 00 IDLE = 0111, 01 STANDBY = 0011, 10 HALT = 0000, 11 HIBERNATE = 0000.
- R4: An idle_exec pulse seen in run moves the block to sleep at that clock edge, and lp_active goes high.
- R5: In IDLE, a high irq_any at a clock edge starts the wake.
- R6: In STANDBY, wake_pin must be sampled high on N+2 consecutive clocks; the wake starts on the following edge. Any low sample restarts the count, so a shorter pulse does not wake.
- R7: In STANDBY, wdog_irq starts the wake only when bit 15 is 1. When bit 15 is 0, wdog_irq is ignored.
- R8: In HALT and HIBERNATE, only wake_pin wakes the block, on its first high sample. irq_any is ignored.
- R9: Wake sequence, one cycle per step:
  - first, osc and wdog come on while cpu stays off and per keeps its sleep value;
  - next, per comes on;
  - then cpu comes on together with a one-cycle wake_done;
  - after that, the block is back in run.
- R10: While asleep in HIBERNATE, io_iso equals bit 31 and mem_off is high when bits [17:16] are 01. Outside that state, both are low.
- R11: While lp_active is high, register writes and idle_exec pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| idle_exec | input | 1 | One-cycle idle-instruction pulse |
| irq_any | input | 1 | Any enabled interrupt pending |
| wdog_irq | input | 1 | Watchdog interrupt |
| wake_pin | input | 1 | External wake input (already port-qualified) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdog_clk_en | output | 1 | Watchdog clock enable |
| osc_en | output | 1 | Oscillator/PLL enable |
| mem_off | output | 1 | Power off the retained memories |
| io_iso | output | 1 | IO isolation request |
| lp_active | output | 1 | Low-power mode or wake sequence in progress |
| wake_done | output | 1 | One-cycle pulse when the wake completes |

## Verification
The assertions check several properties on every cycle:
- the enable hierarchy (cpu needs per, per and wdog need osc);
- all clocks on in run;
- the register staying frozen while lp_active is high;
- isolation only with the oscillator off;
- wake_done being a single pulse that follows a cycle with per on and cpu off.

Some behaviours only the bench scenarios can show:
- the exact N+2 filter length, including the short glitch that must not wake;
- the watchdog wake enable being honoured;
- which wake source applies in each mode;
- the per-mode gating table.

For these, the bench compares every cycle against a behavioural model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_WK_OSC,
    ST_WK_PER,
    ST_WK_CPU
  } lpm_state_e;

  typedef enum logic [1:0] {
    MD_IDLE = 2'b00,
    MD_STBY = 2'b01,
    MD_HALT = 2'b10,
    MD_HIB  = 2'b11
  } lpm_mode_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic wdog;
    logic osc;
  } clk_gates_t;

  // Control register field positions (software-visible layout)
  localparam int unsigned MODE_LSB = 0;
  localparam int unsigned QUAL_LSB = 2;
  localparam int unsigned WDW_BIT  = 15;
  localparam int unsigned MEM_LSB  = 16;
  localparam int unsigned ISO_BIT  = 31;

  localparam clk_gates_t GATES_ALL_ON = '{cpu: 1'b1, per: 1'b1, wdog: 1'b1, osc: 1'b1};

  function automatic clk_gates_t sleep_gates(lpm_mode_e m);
    clk_gates_t g;
    case (m)
      MD_IDLE: g = '{cpu: 1'b0, per: 1'b1, wdog: 1'b1, osc: 1'b1};
      MD_STBY: g = '{cpu: 1'b0, per: 1'b0, wdog: 1'b1, osc: 1'b1};
      default: g = '{cpu: 1'b0, per: 1'b0, wdog: 1'b0, osc: 1'b0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned QUAL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_allow,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import lpm_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] WMASK =
      (DATA_W'(3) << MODE_LSB) |
      (((ONE << QUAL_W) - ONE) << QUAL_LSB) |
      (ONE << WDW_BIT) |
      (DATA_W'(3) << MEM_LSB) |
      (ONE << ISO_BIT);
  localparam logic [DATA_W-1:0] RST_VAL = ((ONE << QUAL_W) - ONE) << QUAL_LSB;

  logic [DATA_W-1:0] reg_q, reg_d;
  logic              reg_ce;

  assign reg_ce = wr_en & wr_allow;

  always_comb begin
    reg_d = reg_q;
    if (reg_ce) reg_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= RST_VAL;
    else if (reg_ce) reg_q <= reg_d;
  end

  assign rdata = reg_q;

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int unsigned QUAL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic [QUAL_W-1:0] qual_n,
  output logic              qualified
);
  localparam int unsigned CNT_W = QUAL_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] target;

  assign target = {1'b0, qual_n} + CNT_W'(2);

  always_comb begin
    if (!pin)                 cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qualified = (cnt_q >= target);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle_exec,
  input  lpm_pkg::lpm_mode_e  mode,
  input  logic                irq_any,
  input  logic                wdog_irq,
  input  logic                wdog_wake_en,
  input  logic                pin_raw,
  input  logic                pin_qual,
  output lpm_pkg::lpm_state_e state,
  output lpm_pkg::clk_gates_t gates
);
  import lpm_pkg::*;

  lpm_state_e st_q, st_d;
  logic       wake_hit;
  clk_gates_t slp;

  assign slp = sleep_gates(mode);

  always_comb begin
    case (mode)
      MD_IDLE: wake_hit = irq_any;
      MD_STBY: wake_hit = pin_qual | (wdog_wake_en & wdog_irq);
      default: wake_hit = pin_raw;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:    if (idle_exec) st_d = ST_SLEEP;
      ST_SLEEP:  if (wake_hit)  st_d = ST_WK_OSC;
      ST_WK_OSC: st_d = ST_WK_PER;
      ST_WK_PER: st_d = ST_WK_CPU;
      default:   st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  always_comb begin
    case (st_q)
      ST_SLEEP:  gates = slp;
      ST_WK_OSC: gates = '{cpu: 1'b0, per: slp.per, wdog: 1'b1, osc: 1'b1};
      ST_WK_PER: gates = '{cpu: 1'b0, per: 1'b1, wdog: 1'b1, osc: 1'b1};
      default:   gates = GATES_ALL_ON;
    endcase
  end

  assign state = st_q;

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned QUAL_W = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              idle_exec,
  input  logic              irq_any,
  input  logic              wdog_irq,
  input  logic              wake_pin,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              wdog_clk_en,
  output logic              osc_en,
  output logic              mem_off,
  output logic              io_iso,
  output logic              lp_active,
  output logic              wake_done
);
  import lpm_pkg::*;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [DATA_W-1:0] cfg_q;
  lpm_state_e        state;
  clk_gates_t        gates;
  lpm_mode_e         mode;
  logic              pin_qual;
  logic              in_hib;

  assign mode = lpm_mode_e'(cfg_q[MODE_LSB +: 2]);

  lpm_cfg_reg #(.DATA_W(DATA_W), .QUAL_W(QUAL_W)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (cfg_wr),
    .wr_allow (state == ST_RUN),
    .wdata    (cfg_wdata),
    .rdata    (cfg_q)
  );

  lpm_wake_qual #(.QUAL_W(QUAL_W)) i_qual (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin       (wake_pin),
    .qual_n    (cfg_q[QUAL_LSB +: QUAL_W]),
    .qualified (pin_qual)
  );

  lpm_fsm i_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .idle_exec    (idle_exec),
    .mode         (mode),
    .irq_any      (irq_any),
    .wdog_irq     (wdog_irq),
    .wdog_wake_en (cfg_q[WDW_BIT]),
    .pin_raw      (wake_pin),
    .pin_qual     (pin_qual),
    .state        (state),
    .gates        (gates)
  );

  assign in_hib      = (state == ST_SLEEP) && (mode == MD_HIB);
  assign cfg_rdata   = cfg_q;
  assign cpu_clk_en  = gates.cpu;
  assign per_clk_en  = gates.per;
  assign wdog_clk_en = gates.wdog;
  assign osc_en      = gates.osc;
  assign io_iso      = in_hib & cfg_q[ISO_BIT];
  assign mem_off     = in_hib & (cfg_q[MEM_LSB +: 2] == 2'b01);
  assign lp_active   = (state != ST_RUN);
  assign wake_done   = (state == ST_WK_CPU);

endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              cpu_clk_en,
  input logic              per_clk_en,
  input logic              wdog_clk_en,
  input logic              osc_en,
  input logic              io_iso,
  input logic              lp_active,
  input logic              wake_done
);

  // R2
  run_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_active |-> (cpu_clk_en && per_clk_en && wdog_clk_en && osc_en));

  // R3
  gate_hier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en |-> per_clk_en) and (per_clk_en |-> osc_en) and (wdog_clk_en |-> osc_en));

  // R9
  wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (cpu_clk_en && $past(per_clk_en) && !$past(cpu_clk_en)));

  // R9
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> (!wake_done && !lp_active));

  // R10
  iso_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_iso |-> (lp_active && !osc_en));

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_active && $past(lp_active)) |-> $stable(cfg_rdata));

endmodule

bind lpm_sequencer lpm_sequencer_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rdata   (cfg_rdata),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .wdog_clk_en (wdog_clk_en),
  .osc_en      (osc_en),
  .io_iso      (io_iso),
  .lp_active   (lp_active),
  .wake_done   (wake_done)
);

// File: tb/test_lpm_sequencer.sv
`timescale 1ns/1ps
module test_lpm_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        idle_exec = 1'b0, irq_any = 1'b0, wdog_irq = 1'b0, wake_pin = 1'b0;
  logic        cpu_clk_en, per_clk_en, wdog_clk_en, osc_en, mem_off, io_iso, lp_active, wake_done;

  always #5 clk = ~clk;

  lpm_sequencer i_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .idle_exec(idle_exec), .irq_any(irq_any), .wdog_irq(wdog_irq), .wake_pin(wake_pin),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wdog_clk_en(wdog_clk_en), .osc_en(osc_en),
    .mem_off(mem_off), .io_iso(io_iso), .lp_active(lp_active), .wake_done(wake_done));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 run, 1 asleep, 2..4 the three wake steps
  localparam logic [31:0] MASK = 32'h8003_80FF;
  int          ms;
  logic [31:0] mcfg;
  int          mcnt;
  bit          mwk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mcfg = 32'h0000_00FC; mcnt = 0;
    end else begin
      case (mcfg[1:0])
        2'd0:    mwk = irq_any;
        2'd1:    mwk = (mcnt >= int'(mcfg[7:2]) + 2) || (mcfg[15] && wdog_irq);
        default: mwk = wake_pin;
      endcase
      case (ms)
        0: begin
             if (cfg_wr) mcfg = cfg_wdata & MASK;
             if (idle_exec) ms = 1;
           end
        1: if (mwk) ms = 2;
        2: ms = 3;
        3: ms = 4;
        default: ms = 0;
      endcase
      mcnt = wake_pin ? ((mcnt < 127) ? mcnt + 1 : 127) : 0;
    end
  end

  function automatic logic [3:0] table_gates(logic [1:0] m);
    case (m)
      2'd0: return 4'b0111;
      2'd1: return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] eg;
      string      rq;
      case (ms)
        0: begin eg = 4'b1111; rq = "R2"; end
        1: begin eg = table_gates(mcfg[1:0]); rq = "R3"; end
        2: begin eg = {1'b0, table_gates(mcfg[1:0])[2], 2'b11}; rq = "R9"; end
        3: begin eg = 4'b0111; rq = "R9"; end
        default: begin eg = 4'b1111; rq = "R9"; end
      endcase
      chk(rq, {28'd0, cpu_clk_en, per_clk_en, wdog_clk_en, osc_en}, {28'd0, eg});
      chk("R1/R11 rdata", cfg_rdata, mcfg);
      chk("R9 wake_done", {31'd0, wake_done}, {31'd0, ms == 4});
      chk("R4 lp_active", {31'd0, lp_active}, {31'd0, ms != 0});
      chk("R10 io_iso", {31'd0, io_iso}, {31'd0, ms == 1 && mcfg[1:0] == 2'd3 && mcfg[31]});
      chk("R10 mem_off", {31'd0, mem_off},
          {31'd0, ms == 1 && mcfg[1:0] == 2'd3 && mcfg[17:16] == 2'b01});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    cfg_wr = 1'b1; cfg_wdata = d; cyc(1); cfg_wr = 1'b0;
  endtask

  task automatic sleep_now();
    idle_exec = 1'b1; cyc(1); idle_exec = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(4);
    // R1 reset value
    chk("R1 reset", cfg_rdata, 32'h0000_00FC);
    wr(32'hFFFF_FFFF); cyc(1);
    chk("R1 mask", cfg_rdata, 32'h8003_80FF);

    // R5 IDLE wake by interrupt
    wr(32'h0000_00FC); sleep_now(); cyc(2);
    chk("R4 asleep", {31'd0, lp_active}, 32'd1);
    chk("R3 idle gates", {28'd0, cpu_clk_en, per_clk_en, wdog_clk_en, osc_en}, 32'h7);
    irq_any = 1'b1; cyc(1); irq_any = 1'b0; cyc(5);
    chk("R5 woke", {31'd0, lp_active}, 32'd0);

    // R6 STANDBY with N=3: 4-cycle glitch rejected, exactly 5 cycles accepted
    wr(32'h0000_000D); sleep_now(); cyc(2);
    wake_pin = 1'b1; cyc(4); wake_pin = 1'b0; cyc(3);
    chk("R6 glitch ignored", {31'd0, lp_active}, 32'd1);
    // R7 watchdog ignored when bit15 clear
    wdog_irq = 1'b1; cyc(1); wdog_irq = 1'b0; cyc(2);
    chk("R7 wdog ignored", {31'd0, lp_active}, 32'd1);
    // R11 write and idle pulse ignored while asleep
    wr(32'h0000_0002); sleep_now(); cyc(1);
    chk("R11 write ignored", cfg_rdata, 32'h0000_000D);
    wake_pin = 1'b1; cyc(5); wake_pin = 1'b0; cyc(6);
    chk("R6 qualified wake", {31'd0, lp_active}, 32'd0);

    // R7 watchdog wake when enabled
    wr(32'h0000_800D); sleep_now(); cyc(2);
    wdog_irq = 1'b1; cyc(1); wdog_irq = 1'b0; cyc(5);
    chk("R7 wdog wake", {31'd0, lp_active}, 32'd0);

    // R8 HALT: interrupt ignored, pin wakes
    wr(32'h0000_0002); sleep_now(); cyc(2);
    irq_any = 1'b1; cyc(2); irq_any = 1'b0; cyc(1);
    chk("R8 irq ignored", {31'd0, lp_active}, 32'd1);
    chk("R3 halt gates", {28'd0, cpu_clk_en, per_clk_en, wdog_clk_en, osc_en}, 32'h0);
    wake_pin = 1'b1; cyc(1); wake_pin = 1'b0;
    // R9 wake sequence sampled step by step
    chk("R9 osc step", {28'd0, cpu_clk_en, per_clk_en, wdog_clk_en, osc_en}, 32'h3);
    cyc(1);
    chk("R9 per step", {28'd0, cpu_clk_en, per_clk_en, wdog_clk_en, osc_en}, 32'h7);
    cyc(1);
    chk("R9 cpu step", {31'd0, wake_done}, 32'd1);
    cyc(1);
    chk("R9 back to run", {30'd0, wake_done, lp_active}, 32'd0);

    // R10 HIBERNATE with isolation and memories off
    wr(32'h8001_0003); sleep_now(); cyc(2);
    chk("R10 iso", {30'd0, io_iso, mem_off}, 32'h3);
    wake_pin = 1'b1; cyc(1); wake_pin = 1'b0; cyc(5);
    chk("R10 released", {30'd0, io_iso, mem_off}, 32'h0);

    // R10 HIBERNATE with defaults: nothing asserted
    wr(32'h0000_0003); sleep_now(); cyc(2);
    chk("R10 iso off", {30'd0, io_iso, mem_off}, 32'h0);
    wake_pin = 1'b1; cyc(1); wake_pin = 1'b0; cyc(5);

    finish_run();
  end

endmodule